// File: doc/BRIEF.md
# Flash Self-Write Sequencing Controller

This block lets a small processor core erase and reprogram rows of its own program memory. The core reaches it through a simple register write port. It writes a row/word address, a 14-bit data word split over two byte registers and a control byte. An operation only starts after the core writes a two-byte unlock key into a separate key register. The controller then spends a fixed setup window in which the core must discard the instructions it has already fetched. After that it either drops the word into a 32-entry latch buffer, or hands a whole row to the array and holds the core stalled until the array finishes.

The array is a behavioural model. It holds `ROWS` rows of 32 words, each 14 bits, and takes `BUSY_CYC` clock cycles for every erase or program. The stall only freezes instruction execution. The clock keeps running, so the stall is not a sleep state. A row commit copies all 32 latches into the row in one step and then resets every latch to the erased value 3FFFh.

Top module: `flash_selfwrite_ctrl`

## Requirements
- R1: A start request is a write of the control register (reg_sel 0) with bit 0 set. It is accepted only if the two most recent key-register writes (reg_sel 1) were 55h followed by AAh. Any other key byte ends the sequence, and every start request uses it up, whether the request is accepted or not. A request without a valid key has no effect: bit 0 reads back 0 and core_squash stays low.
- R2: After an accepted start, core_squash is high for exactly two cycles, beginning the cycle after the control write.
- R3: With latch-only (control bit 4) set and erase (bit 3) clear, the operation writes {data_hi[5:0], data_lo[7:0]} into latch address[4:0] and never raises core_stall. Address low is reg_sel 2, address high is reg_sel 3 (6 bits), data low is reg_sel 4 and data high is reg_sel 5, of which only bits 5:0 are kept.
- R4: With latch-only and erase both clear, the current word is first loaded into its latch. All 32 latches are then written into row address[13:5], and core_stall is high for BUSY_CYC cycles straight after the setup window. Rows numbered ROWS and above do not exist: they read as 3FFFh and commits to them are dropped.
- R5: After a row commit, every latch holds 3FFFh.
- R6: With erase set, the operation sets every word of row address[13:5] to 3FFFh and stalls the core for BUSY_CYC cycles. Other rows and the latches are unchanged.
- R7: Control bit 0 reads 1 from the cycle after an accepted start until the operation completes, and 0 afterwards.
- R8: A start request is rejected, and error bit 2 is set, if write-enable (bit 1) is 0, config-space (bit 5) is 1, or program-memory select (bit 6) is 0. Any other control write loads bit 2 from the written data.
- R9: While an operation is in progress (setup or busy), writes to every register are ignored.
- R10: After reset the control register reads 00h, core_squash and core_stall are low, and all array words and latches hold 3FFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 control, 1 key, 2 addr low, 3 addr high, 4 data low, 5 data high) |
| reg_wdata | input | 8 | Register write data |
| ctrl_rdata | output | 8 | Control register readback {0, mem, cfg, latch-only, erase, error, wren, start} |
| core_squash | output | 1 | Setup window: fetched instructions must be discarded |
| core_stall | output | 1 | Core execution frozen while the array is busy |
| rd_addr | input | 14 | Program memory read address |
| rd_data | output | 14 | Program memory read data (combinational) |

## Verification
A key tracker left in the armed state would let a later start through without a key. That shows up as a two-cycle core_squash pulse on the very next unkeyed start, so the bench reruns starts after a finished operation and after wrong key bytes. A latch buffer that is not cleared only becomes visible after the next commit, because untouched words then read back old data instead of 3FFFh. An off-by-one in the setup or busy counters moves the squash and stall edges by a cycle, and the bench catches this by counting the cycles each one stays high on every operation.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  localparam int WORD_W  = 14;
  localparam int LATCH_N = 32;
  localparam int IDX_W   = $clog2(LATCH_N);
  localparam int ADDR_W  = 14;
  localparam int ROWA_W  = ADDR_W - IDX_W;

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_KEY  = 3'd1;
  localparam logic [2:0] SEL_ALO  = 3'd2;
  localparam logic [2:0] SEL_AHI  = 3'd3;
  localparam logic [2:0] SEL_DLO  = 3'd4;
  localparam logic [2:0] SEL_DHI  = 3'd5;

  localparam int CB_START = 0;
  localparam int CB_WREN  = 1;
  localparam int CB_ERR   = 2;
  localparam int CB_ERASE = 3;
  localparam int CB_LONLY = 4;
  localparam int CB_CFG   = 5;
  localparam int CB_MEM   = 6;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_BUSY} seq_state_e;
  typedef enum logic [1:0] {K_NONE, K_FIRST, K_ARMED} key_state_e;
endpackage

// File: rtl/fsw_key_unlock.sv
module fsw_key_unlock #(
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       consume,
  output logic       armed
);
  import fsw_pkg::*;

  key_state_e st_q, st_n;

  always_comb begin
    st_n = st_q;
    if (consume) begin
      st_n = K_NONE;
    end else if (key_wr) begin
      if (key_byte == KEY_A)                       st_n = K_FIRST;
      else if (key_byte == KEY_B && st_q == K_FIRST) st_n = K_ARMED;
      else                                         st_n = K_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= K_NONE;
    else        st_q <= st_n;
  end

  assign armed = (st_q == K_ARMED);
endmodule

// File: rtl/fsw_latch_buf.sv
module fsw_latch_buf #(
  parameter int WORDS = 32,
  parameter int W     = 14,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [W-1:0]       wr_data,
  input  logic               clr,
  output logic [WORDS*W-1:0] words
);
  for (genvar i = 0; i < WORDS; i++) begin : g_latch
    logic [W-1:0] lat_q;
    logic         hit;
    assign hit = wr_en && (wr_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lat_q <= '1;
      else if (clr) lat_q <= '1;
      else if (hit) lat_q <= wr_data;
    end
    assign words[i*W +: W] = lat_q;
  end
endmodule

// File: rtl/fsw_array_model.sv
module fsw_array_model #(
  parameter int ROWS     = 4,
  parameter int WORDS    = 32,
  parameter int W        = 14,
  parameter int RA_W     = 9,
  parameter int BUSY_CYC = 20,
  localparam int IW      = $clog2(WORDS),
  localparam int CNT_W   = $clog2(BUSY_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               erase,
  input  logic [RA_W-1:0]    row_sel,
  input  logic [WORDS*W-1:0] row_data,
  input  logic [RA_W-1:0]    rd_row,
  input  logic [IW-1:0]      rd_idx,
  output logic               busy,
  output logic               done,
  output logic [W-1:0]       rd_data
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             erase_q;
  logic [RA_W-1:0]  row_q;
  logic [W-1:0]     mem [ROWS][WORDS];

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_n = cnt_q;
    if (start)     cnt_n = CNT_W'(BUSY_CYC);
    else if (busy) cnt_n = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      erase_q <= 1'b0;
      row_q   <= '0;
    end else begin
      cnt_q <= cnt_n;
      if (start) begin
        erase_q <= erase;
        row_q   <= row_sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int w = 0; w < WORDS; w++)
          mem[r][w] <= '1;
    end else if (done) begin
      for (int r = 0; r < ROWS; r++)
        if (row_q == RA_W'(r))
          for (int w = 0; w < WORDS; w++)
            mem[r][w] <= erase_q ? '1 : row_data[w*W +: W];
    end
  end

  always_comb begin
    rd_data = '1;
    for (int r = 0; r < ROWS; r++)
      if (rd_row == RA_W'(r)) rd_data = mem[r][rd_idx];
  end
endmodule

// File: rtl/flash_selfwrite_ctrl.sv
module flash_selfwrite_ctrl #(
  parameter int ROWS      = 4,
  parameter int BUSY_CYC  = 20,
  parameter int SETUP_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [2:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  ctrl_rdata,
  output logic        core_squash,
  output logic        core_stall,
  input  logic [13:0] rd_addr,
  output logic [13:0] rd_data
);
  import fsw_pkg::*;

  localparam int SC_W = $clog2(SETUP_CYC) + 1;

  seq_state_e    st_q, st_n;
  logic [SC_W-1:0] scnt_q, scnt_n;
  logic [7:0]    alo_q, dlo_q;
  logic [5:0]    ahi_q, dhi_q;
  logic          start_q, wren_q, err_q, erase_q, lonly_q, cfg_q, mem_q;
  logic          start_n, err_n;

  logic          idle, wr_ok, ctrl_wr, start_req, cfg_bad, accept, reject;
  logic          key_armed, setup_last, latch_wr, latch_clr, arr_start;
  logic          arr_busy, arr_done, finish;
  logic [ADDR_W-1:0] addr_full;
  logic [WORD_W-1:0] word_in;
  logic [LATCH_N*WORD_W-1:0] latch_words;

  assign idle      = (st_q == SQ_IDLE);
  assign wr_ok     = reg_wr_en && idle;
  assign ctrl_wr   = wr_ok && (reg_sel == SEL_CTRL);
  assign start_req = ctrl_wr && reg_wdata[CB_START];
  assign cfg_bad   = !reg_wdata[CB_WREN] || reg_wdata[CB_CFG] || !reg_wdata[CB_MEM];
  assign reject    = start_req && cfg_bad;
  assign accept    = start_req && !cfg_bad && key_armed;

  assign addr_full = {ahi_q, alo_q};
  assign word_in   = {dhi_q, dlo_q};

  assign setup_last = (st_q == SQ_SETUP) && (scnt_q == SC_W'(SETUP_CYC - 1));
  assign latch_wr   = setup_last && !erase_q;
  assign arr_start  = setup_last && (erase_q || !lonly_q);
  assign latch_clr  = (st_q == SQ_BUSY) && arr_done && !erase_q;
  assign finish     = (setup_last && !erase_q && lonly_q) ||
                      ((st_q == SQ_BUSY) && arr_done);

  fsw_key_unlock u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (wr_ok && (reg_sel == SEL_KEY)),
    .key_byte (reg_wdata),
    .consume  (start_req),
    .armed    (key_armed)
  );

  fsw_latch_buf #(.WORDS(LATCH_N), .W(WORD_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (latch_wr),
    .wr_idx  (addr_full[IDX_W-1:0]),
    .wr_data (word_in),
    .clr     (latch_clr),
    .words   (latch_words)
  );

  fsw_array_model #(
    .ROWS(ROWS), .WORDS(LATCH_N), .W(WORD_W), .RA_W(ROWA_W), .BUSY_CYC(BUSY_CYC)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (arr_start),
    .erase    (erase_q),
    .row_sel  (addr_full[ADDR_W-1:IDX_W]),
    .row_data (latch_words),
    .rd_row   (rd_addr[ADDR_W-1:IDX_W]),
    .rd_idx   (rd_addr[IDX_W-1:0]),
    .busy     (arr_busy),
    .done     (arr_done),
    .rd_data  (rd_data)
  );

  always_comb begin
    st_n    = st_q;
    scnt_n  = scnt_q;
    start_n = start_q;
    err_n   = err_q;
    case (st_q)
      SQ_IDLE: begin
        scnt_n = '0;
        if (accept) st_n = SQ_SETUP;
      end
      SQ_SETUP: begin
        scnt_n = scnt_q + SC_W'(1);
        if (setup_last) st_n = arr_start ? SQ_BUSY : SQ_IDLE;
      end
      SQ_BUSY: begin
        if (arr_done || !arr_busy) st_n = SQ_IDLE;
      end
      default: st_n = SQ_IDLE;
    endcase
    if (ctrl_wr) begin
      start_n = accept;
      err_n   = reject || reg_wdata[CB_ERR];
    end
    if (finish) start_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      scnt_q  <= '0;
      start_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      scnt_q  <= scnt_n;
      start_q <= start_n;
      err_q   <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wren_q  <= 1'b0;
      erase_q <= 1'b0;
      lonly_q <= 1'b0;
      cfg_q   <= 1'b0;
      mem_q   <= 1'b0;
    end else if (ctrl_wr) begin
      wren_q  <= reg_wdata[CB_WREN];
      erase_q <= reg_wdata[CB_ERASE];
      lonly_q <= reg_wdata[CB_LONLY];
      cfg_q   <= reg_wdata[CB_CFG];
      mem_q   <= reg_wdata[CB_MEM];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alo_q <= '0;
      ahi_q <= '0;
      dlo_q <= '0;
      dhi_q <= '0;
    end else if (wr_ok) begin
      if (reg_sel == SEL_ALO) alo_q <= reg_wdata;
      if (reg_sel == SEL_AHI) ahi_q <= reg_wdata[5:0];
      if (reg_sel == SEL_DLO) dlo_q <= reg_wdata;
      if (reg_sel == SEL_DHI) dhi_q <= reg_wdata[5:0];
    end
  end

  assign ctrl_rdata  = {1'b0, mem_q, cfg_q, lonly_q, erase_q, err_q, wren_q, start_q};
  assign core_squash = (st_q == SQ_SETUP);
  assign core_stall  = (st_q == SQ_BUSY);
endmodule

// File: rtl/fsw_ctrl_checker.sv
module fsw_ctrl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr_en,
  input logic [2:0] reg_sel,
  input logic [7:0] reg_wdata,
  input logic [7:0] ctrl_rdata,
  input logic       core_squash,
  input logic       core_stall
);
  logic start_wr;
  assign start_wr = reg_wr_en && (reg_sel == 3'd0) && reg_wdata[0];

  // R1: a setup window only opens right after a start request
  assert_squash_needs_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_squash) |-> $past(start_wr));

  // R2: the setup window lasts two cycles
  assert_squash_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_squash) |=> core_squash);
  assert_squash_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_squash && $past(core_squash)) |=> !core_squash);

  // R4: a stall never overlaps the setup window and always follows it
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_squash && core_stall));
  assert_stall_after_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_stall) |-> $past(core_squash));

  // R7: start bit stays visible while the core is held
  assert_start_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_stall || core_squash) |-> ctrl_rdata[0]);

  // R8: a start without write enable is rejected and flagged
  assert_reject_no_wren_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !reg_wdata[1] && !ctrl_rdata[0]) |=> (!core_squash && ctrl_rdata[2]));
endmodule

bind flash_selfwrite_ctrl fsw_ctrl_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_sel     (reg_sel),
  .reg_wdata   (reg_wdata),
  .ctrl_rdata  (ctrl_rdata),
  .core_squash (core_squash),
  .core_stall  (core_stall)
);

// File: tb/flash_selfwrite_ctrl_tb_top.sv
module flash_selfwrite_ctrl_tb_top;
  localparam int BUSY = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  ctrl_rdata;
  logic        core_squash, core_stall;
  logic [13:0] rd_addr = 14'd0;
  logic [13:0] rd_data;

  int compared = 0;
  int mismatched = 0;
  string req_q[$];
  int    exp_q[$];
  int    act_q[$];
  event  chk_ev;

  flash_selfwrite_ctrl #(.ROWS(4), .BUSY_CYC(BUSY), .SETUP_CYC(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .core_squash(core_squash),
    .core_stall(core_stall), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  task automatic drain();
    while (exp_q.size() > 0) begin
      string r;
      int e, a;
      r = req_q.pop_front();
      e = exp_q.pop_front();
      a = act_q.pop_front();
      compared++;
      if (e != a) begin
        mismatched++;
        $display("FAIL %s: actual %0h expected %0h", r, a, e);
      end
    end
  endtask

  initial forever begin
    @(chk_ev);
    drain();
  end

  task automatic expect_item(string r, int e, int a);
    req_q.push_back(r);
    exp_q.push_back(e);
    act_q.push_back(a);
    ->chk_ev;
  endtask

  task automatic wr(logic [2:0] s, logic [7:0] d);
    reg_wr_en = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(3'd1, 8'h55);
    wr(3'd1, 8'hAA);
  endtask

  task automatic load(logic [13:0] a, logic [13:0] d);
    wr(3'd2, a[7:0]);
    wr(3'd3, {2'b00, a[13:8]});
    wr(3'd4, d[7:0]);
    wr(3'd5, {2'b00, d[13:8]});
  endtask

  // issue a start and count squash / stall cycles until both are low
  task automatic run_op(logic [7:0] c, output int sq, output int st, output int bit0);
    sq = 0; st = 0;
    wr(3'd0, c);
    bit0 = int'(ctrl_rdata[0]);
    for (int k = 0; k < 1000 && (core_squash || core_stall); k++) begin
      if (core_squash) sq++;
      if (core_stall) st++;
      @(negedge clk);
    end
  endtask

  function automatic logic [13:0] pat(int i);
    return 14'((i * 419 + 7) & 16'h3FFF);
  endfunction

  task automatic rd_chk(string r, logic [13:0] a, logic [13:0] e);
    rd_addr = a;
    #1;
    expect_item(r, int'(e), int'(rd_data));
  endtask

  initial begin
    #2_000_000;
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int sq, st, b0;
    logic [13:0] w7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    expect_item("R10 ctrl", 0, int'(ctrl_rdata));
    expect_item("R10 squash", 0, int'(core_squash));
    expect_item("R10 stall", 0, int'(core_stall));
    rd_chk("R10 array", 14'h0000, 14'h3FFF);

    // R1 no key
    load(14'h0000, 14'h0123);
    run_op(8'h53, sq, st, b0);
    expect_item("R1 nokey squash", 0, sq);
    expect_item("R1 nokey ctrl", 'h52, int'(ctrl_rdata));
    // R1 wrong order
    wr(3'd1, 8'hAA); wr(3'd1, 8'h55);
    run_op(8'h53, sq, st, b0);
    expect_item("R1 order squash", 0, sq);
    // R1 wrong middle byte
    wr(3'd1, 8'h55); wr(3'd1, 8'h12); wr(3'd1, 8'hAA);
    run_op(8'h53, sq, st, b0);
    expect_item("R1 badbyte squash", 0, sq);

    // R2 R3 fill row 0 words 0..30 with latch-only starts
    for (int i = 0; i < 31; i++) begin
      unlock();
      load(14'(i), pat(i));
      if (i == 7) wr(3'd5, 8'hFF);
      run_op(8'h53, sq, st, b0);
      expect_item("R2 latch squash", 2, sq);
      expect_item("R3 latch nostall", 0, st);
    end
    // R4 commit on word 31
    unlock();
    load(14'd31, pat(31));
    run_op(8'h43, sq, st, b0);
    expect_item("R2 commit squash", 2, sq);
    expect_item("R4 commit stall", BUSY, st);
    expect_item("R7 start during", 1, b0);
    expect_item("R7 start after", 0, int'(ctrl_rdata[0]));
    w7 = {6'h3F, pat(7)[7:0]};
    for (int i = 0; i < 32; i++)
      rd_chk("R4 row0 word", 14'(i), (i == 7) ? w7 : pat(i));

    // R1 key consumed: no second start
    run_op(8'h43, sq, st, b0);
    expect_item("R1 reuse squash", 0, sq);

    // R5 latches cleared: single-word commit leaves others erased
    unlock();
    load(14'd5, 14'h0AAA);
    run_op(8'h43, sq, st, b0);
    expect_item("R4 second stall", BUSY, st);
    rd_chk("R5 word5", 14'd5, 14'h0AAA);
    rd_chk("R5 word0", 14'd0, 14'h3FFF);
    rd_chk("R5 word31", 14'd31, 14'h3FFF);

    // R8 rejections
    unlock();
    run_op(8'h41, sq, st, b0);
    expect_item("R8 nowren squash", 0, sq);
    expect_item("R8 nowren err", 1, int'(ctrl_rdata[2]));
    wr(3'd0, 8'h00);
    expect_item("R8 err clear", 0, int'(ctrl_rdata));
    unlock();
    run_op(8'h63, sq, st, b0);
    expect_item("R8 cfg squash", 0, sq);
    expect_item("R8 cfg err", 1, int'(ctrl_rdata[2]));
    unlock();
    run_op(8'h03, sq, st, b0);
    expect_item("R8 mem err", 1, int'(ctrl_rdata[2]));

    // R6 erase: program row 2, then erase it
    unlock();
    load(14'h0043, 14'h1234);
    run_op(8'h43, sq, st, b0);
    rd_chk("R4 row2 word3", 14'h0043, 14'h1234);
    unlock();
    wr(3'd2, 8'h4A);
    run_op(8'h4B, sq, st, b0);
    expect_item("R6 erase squash", 2, sq);
    expect_item("R6 erase stall", BUSY, st);
    rd_chk("R6 row2 erased", 14'h0043, 14'h3FFF);
    rd_chk("R6 row0 kept", 14'd5, 14'h0AAA);

    // R9 writes ignored during an operation
    unlock();
    load(14'd1, 14'h0055);
    wr(3'd0, 8'h43);
    wr(3'd2, 8'h09);
    wr(3'd1, 8'h55);
    wr(3'd1, 8'hAA);
    wr(3'd0, 8'h00);
    for (int k = 0; k < 100 && (core_squash || core_stall); k++) @(negedge clk);
    expect_item("R9 ctrl kept", 'h42, int'(ctrl_rdata));
    rd_chk("R9 word1", 14'd1, 14'h0055);
    rd_chk("R9 word9", 14'd9, 14'h3FFF);
    rd_chk("R5 word5 cleared", 14'd5, 14'h3FFF);
    run_op(8'h43, sq, st, b0);
    expect_item("R9 key ignored", 0, sq);

    @(negedge clk);
    drain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule